// File: doc/BRIEF.md
# DDR2 SDRAM power-up initialization sequencer

This block sits on the controller side of a DDR2 memory interface. It takes the memory from power-on to a usable state. It waits for a power-good indication and keeps the clock-enable line low through a stable-clock window. It then raises clock enable and idles the bus, and after that it issues the fixed series of precharge, mode-register, refresh and driver-calibration commands that the memory requires. When the final spacing interval has run out, it raises a done flag and leaves the bus idle so that the normal controller can take over.

All waits are counted in clock cycles. Each count is derived at elaboration from a clock-period parameter and a set of time parameters, and is rounded up. The operating fields for the four mode registers come in as parallel inputs. The sequencer forces only the bits that the initialization procedure dictates (DLL enable, DLL reset and the three driver-calibration bits) and passes every other bit through unchanged.

Top module: `ddr2_init_seq`

## Requirements
- R1: While reset is asserted, and after reset while power-good is low, cke_o is 0, the bus carries NOP, ba_o and addr_o are 0, and init_done_o is 0. NOP is encoded as {cs_no,ras_no,cas_no,we_no} = 0111.
- R2: Power-good is first seen high at a rising clock edge, and the next cycle is the first cycle of the stable-clock window. From that cycle, cke_o stays 0 with NOP for N_STB = ceil(T_STABLE_NS*1000/CLK_PS) cycles and then goes to 1. After that, NOP is held for N_CKE = ceil(T_CKE_NS*1000/CLK_PS) cycles before the first command. cke_o never falls again until the next reset.
- R3: The command order is: precharge-all, write to EMR2 (BA=2), write to EMR3 (BA=3), EMR1 DLL enable (BA=1), MR DLL reset (BA=0), precharge-all, the auto-refreshes, MR operating write, EMR1 driver-calibration default, EMR1 driver-calibration exit.
- R4: Each command lasts exactly one cycle. Precharge-all is 0010 with A10=1 and all other address bits 0. Auto-refresh is 0001 with address 0. A mode write is 0000. BA is 0 for precharge and refresh.
- R5: Each mode write carries its field input, with these forced bits: DLL enable clears A0, A7, A8 and A9. DLL reset sets A8. The MR operating write clears A8. Calibration default clears A0 and sets A9:A7=111. Calibration exit clears A0 and A9:A7.
- R6: The distance between one command and the next is N_MRD after a mode write, N_RP after a precharge-all and N_RFC after an auto-refresh. Each of these is the rounded-up cycle count of its time parameter, but never less than 2.
- R7: The calibration-default write comes at the later of two cycles: N_MRD after the MR operating write, or DLL_GAP+1 cycles after the DLL-reset write. It is therefore never fewer than DLL_GAP cycles after the DLL reset.
- R8: odt_o is 0 at all times.
- R9: init_done_o rises exactly N_MRD cycles after the calibration-exit write. Once high, it stays high with cke_o=1 and NOP on the bus.
- R10: Asserting rst_ni at any point returns the block to the state of R1. When reset is released with power-good high, the complete sequence runs again from the stable-clock window.
- R11: The number of auto-refresh commands is max(REF_N, 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwr_good_i | input | 1 | Supplies stable; starts the sequence |
| mr_fields_i | input | ADDR_W | Operating fields for MR |
| emr1_fields_i | input | ADDR_W | Operating fields for EMR1 |
| emr2_fields_i | input | ADDR_W | Field value written to EMR2 |
| emr3_fields_i | input | ADDR_W | Field value written to EMR3 |
| cke_o | output | 1 | Memory clock enable |
| cs_no | output | 1 | Chip select, active low |
| ras_no | output | 1 | Row strobe, active low |
| cas_no | output | 1 | Column strobe, active low |
| we_no | output | 1 | Write enable, active low |
| odt_o | output | 1 | On-die termination control |
| ba_o | output | 2 | Bank address |
| addr_o | output | ADDR_W | Address bus |
| init_done_o | output | 1 | Initialization complete |

## Verification
The hardest condition to reach is the choice at the calibration-default write between the DLL settle timer and the ordinary spacing after the MR write. Only one of the two governs in any one configuration. The bench therefore runs two instances side by side. In the first, the DLL window outlasts the refresh train. In the second, the window is short, the refresh count is clamped up from 1, and the mode-write spacing is clamped up from one cycle. A reset in the middle of the command stream, with power-good held high, shows that the sequence restarts from the stable-clock window. Further runs with all-zero, all-one and mixed field patterns show which bits are forced and which pass through.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_STABLE, ST_CKE, ST_ISSUE, ST_GAP, ST_DONE
  } init_state_e;

  typedef enum logic [3:0] {
    OP_PREA, OP_EMR2, OP_EMR3, OP_DLL_EN, OP_DLL_RST,
    OP_REF, OP_MR_RUN, OP_OCD_DEF, OP_OCD_EXIT
  } init_op_e;

  function automatic int ceil_div(longint num, longint den);
    return int'((num + den - 1) / den);
  endfunction

  function automatic int max_i(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // step list: fixed prefix, n_ref refreshes, fixed suffix
  function automatic init_op_e op_of(int step, int n_ref);
    if (step == 0 || step == 5) return OP_PREA;
    if (step == 1)              return OP_EMR2;
    if (step == 2)              return OP_EMR3;
    if (step == 3)              return OP_DLL_EN;
    if (step == 4)              return OP_DLL_RST;
    if (step < 6 + n_ref)       return OP_REF;
    if (step == 6 + n_ref)      return OP_MR_RUN;
    if (step == 7 + n_ref)      return OP_OCD_DEF;
    return OP_OCD_EXIT;
  endfunction

endpackage

// File: rtl/ddr2_init_fsm.sv
module ddr2_init_fsm
  import ddr2_init_pkg::*;
#(
  parameter int N_STB   = 1,
  parameter int N_CKE   = 1,
  parameter int N_RP    = 2,
  parameter int N_MRD   = 2,
  parameter int N_RFC   = 2,
  parameter int REF_CNT = 2,
  parameter int CNT_W   = 8,
  parameter int STEP_W  = 4
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     pwr_good_i,
  input  logic     dll_ok_i,
  output logic     cke_o,
  output logic     issue_o,
  output logic     done_o,
  output init_op_e op_o
);

  localparam int LAST = 8 + REF_CNT;
  localparam logic [CNT_W-1:0]  C_STB = CNT_W'(N_STB - 1);
  localparam logic [CNT_W-1:0]  C_CKE = CNT_W'(N_CKE - 1);
  localparam logic [CNT_W-1:0]  C_RP  = CNT_W'(N_RP - 2);
  localparam logic [CNT_W-1:0]  C_MRD = CNT_W'(N_MRD - 2);
  localparam logic [CNT_W-1:0]  C_RFC = CNT_W'(N_RFC - 2);
  localparam logic [STEP_W-1:0] S_LAST = STEP_W'(LAST);

  init_state_e       state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [STEP_W-1:0] step_q;
  init_op_e          op_w, op_nx;
  logic [CNT_W-1:0]  gap_w;

  always_comb begin
    op_w  = op_of(int'(step_q), REF_CNT);
    op_nx = op_of(int'(step_q) + 1, REF_CNT);
    unique case (op_w)
      OP_PREA: gap_w = C_RP;
      OP_REF:  gap_w = C_RFC;
      default: gap_w = C_MRD;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      step_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (pwr_good_i) begin
          state_q <= ST_STABLE;
          cnt_q   <= C_STB;
        end
        ST_STABLE: if (cnt_q == '0) begin
          state_q <= ST_CKE;
          cnt_q   <= C_CKE;
        end else cnt_q <= cnt_q - CNT_W'(1);
        ST_CKE: if (cnt_q == '0) begin
          state_q <= ST_ISSUE;
          step_q  <= '0;
        end else cnt_q <= cnt_q - CNT_W'(1);
        ST_ISSUE: begin
          state_q <= ST_GAP;
          cnt_q   <= gap_w;
        end
        ST_GAP: if (cnt_q != '0) cnt_q <= cnt_q - CNT_W'(1);
          else if (step_q == S_LAST) state_q <= ST_DONE;
          else if (op_nx != OP_OCD_DEF || dll_ok_i) begin
            state_q <= ST_ISSUE;
            step_q  <= step_q + STEP_W'(1);
          end
        ST_DONE: state_q <= ST_DONE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cke_o   = (state_q != ST_IDLE) && (state_q != ST_STABLE);
  assign issue_o = (state_q == ST_ISSUE);
  assign done_o  = (state_q == ST_DONE);
  assign op_o    = op_w;

endmodule

// File: rtl/ddr2_init_dll_wait.sv
module ddr2_init_dll_wait #(
  parameter int DLL_GAP = 200,
  parameter int W       = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic ok_o
);

  localparam logic [W-1:0] LOAD = W'(DLL_GAP - 1);

  logic [W-1:0] cnt_q;
  logic         armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (start_i) begin
      cnt_q   <= LOAD;
      armed_q <= 1'b1;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - W'(1);
    end
  end

  assign ok_o = armed_q && (cnt_q == '0);

endmodule

// File: rtl/ddr2_init_cmd_enc.sv
module ddr2_init_cmd_enc
  import ddr2_init_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              issue_i,
  input  init_op_e          op_i,
  input  logic [ADDR_W-1:0] mr_i,
  input  logic [ADDR_W-1:0] emr1_i,
  input  logic [ADDR_W-1:0] emr2_i,
  input  logic [ADDR_W-1:0] emr3_i,
  output logic              cs_no,
  output logic              ras_no,
  output logic              cas_no,
  output logic              we_no,
  output logic [1:0]        ba_o,
  output logic [ADDR_W-1:0] addr_o
);

  logic [ADDR_W-1:0] emr1_base;

  always_comb begin
    emr1_base    = emr1_i;
    emr1_base[0] = 1'b0;
    emr1_base[9:7] = 3'b000;

    cs_no  = 1'b0;
    ras_no = 1'b1;
    cas_no = 1'b1;
    we_no  = 1'b1;
    ba_o   = 2'd0;
    addr_o = '0;
    if (issue_i) begin
      if (op_i == OP_PREA) begin
        ras_no     = 1'b0;
        we_no      = 1'b0;
        addr_o[10] = 1'b1;
      end else if (op_i == OP_REF) begin
        ras_no = 1'b0;
        cas_no = 1'b0;
      end else begin
        ras_no = 1'b0;
        cas_no = 1'b0;
        we_no  = 1'b0;
        unique case (op_i)
          OP_EMR2: begin ba_o = 2'd2; addr_o = emr2_i; end
          OP_EMR3: begin ba_o = 2'd3; addr_o = emr3_i; end
          OP_DLL_EN, OP_OCD_EXIT: begin ba_o = 2'd1; addr_o = emr1_base; end
          OP_OCD_DEF: begin
            ba_o = 2'd1;
            addr_o = emr1_base;
            addr_o[9:7] = 3'b111;
          end
          OP_DLL_RST: begin addr_o = mr_i; addr_o[8] = 1'b1; end
          default: begin addr_o = mr_i; addr_o[8] = 1'b0; end
        endcase
      end
    end
  end

endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
  import ddr2_init_pkg::*;
#(
  parameter int CLK_PS      = 2500,
  parameter int T_STABLE_NS = 200000,
  parameter int T_CKE_NS    = 400,
  parameter int T_RP_PS     = 15000,
  parameter int T_MRD_PS    = 5000,
  parameter int T_RFC_PS    = 75000,
  parameter int REF_N       = 2,
  parameter int DLL_GAP     = 200,
  parameter int ADDR_W      = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_good_i,
  input  logic [ADDR_W-1:0] mr_fields_i,
  input  logic [ADDR_W-1:0] emr1_fields_i,
  input  logic [ADDR_W-1:0] emr2_fields_i,
  input  logic [ADDR_W-1:0] emr3_fields_i,
  output logic              cke_o,
  output logic              cs_no,
  output logic              ras_no,
  output logic              cas_no,
  output logic              we_no,
  output logic              odt_o,
  output logic [1:0]        ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              init_done_o
);

  localparam int N_STB   = max_i(ceil_div(longint'(T_STABLE_NS) * 1000, CLK_PS), 1);
  localparam int N_CKE   = max_i(ceil_div(longint'(T_CKE_NS) * 1000, CLK_PS), 1);
  localparam int N_RP    = max_i(ceil_div(T_RP_PS, CLK_PS), 2);
  localparam int N_MRD   = max_i(ceil_div(T_MRD_PS, CLK_PS), 2);
  localparam int N_RFC   = max_i(ceil_div(T_RFC_PS, CLK_PS), 2);
  localparam int REF_CNT = max_i(REF_N, 2);
  localparam int CNT_MAX = max_i(max_i(N_STB, N_CKE), max_i(N_RFC, max_i(N_RP, N_MRD)));
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int STEP_W  = $clog2(REF_CNT + 10);
  localparam int DLL_W   = $clog2(DLL_GAP + 1);

  logic     issue, dll_ok;
  init_op_e op;

  ddr2_init_fsm #(
    .N_STB(N_STB), .N_CKE(N_CKE), .N_RP(N_RP), .N_MRD(N_MRD), .N_RFC(N_RFC),
    .REF_CNT(REF_CNT), .CNT_W(CNT_W), .STEP_W(STEP_W)
  ) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .pwr_good_i(pwr_good_i), .dll_ok_i(dll_ok),
    .cke_o(cke_o), .issue_o(issue), .done_o(init_done_o), .op_o(op)
  );

  ddr2_init_dll_wait #(.DLL_GAP(DLL_GAP), .W(DLL_W)) u_dll (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .start_i(issue && (op == OP_DLL_RST)), .ok_o(dll_ok)
  );

  ddr2_init_cmd_enc #(.ADDR_W(ADDR_W)) u_enc (
    .issue_i(issue), .op_i(op),
    .mr_i(mr_fields_i), .emr1_i(emr1_fields_i),
    .emr2_i(emr2_fields_i), .emr3_i(emr3_fields_i),
    .cs_no(cs_no), .ras_no(ras_no), .cas_no(cas_no), .we_no(we_no),
    .ba_o(ba_o), .addr_o(addr_o)
  );

  assign odt_o = 1'b0;

endmodule

// File: rtl/ddr2_init_chk.sv
module ddr2_init_chk #(
  parameter int DLL_GAP = 200
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cke_o,
  input logic       cs_no,
  input logic       ras_no,
  input logic       cas_no,
  input logic       we_no,
  input logic       a10_i,
  input logic [2:0] a987_i,
  input logic [1:0] ba_i,
  input logic       init_done_o
);

  localparam int DW = $clog2(DLL_GAP + 1) + 1;

  logic [3:0]    code;
  logic          is_nop, is_pre, is_mode, dll_rst, ocd_def, seen_q;
  logic [DW-1:0] dist_q;

  assign code    = {cs_no, ras_no, cas_no, we_no};
  assign is_nop  = (code == 4'b0111);
  assign is_pre  = (code == 4'b0010);
  assign is_mode = (code == 4'b0000);
  assign dll_rst = is_mode && (ba_i == 2'd0) && a987_i[1];
  assign ocd_def = is_mode && (ba_i == 2'd1) && (a987_i == 3'b111);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dist_q <= '0;
      seen_q <= 1'b0;
    end else if (dll_rst) begin
      dist_q <= DW'(1);
      seen_q <= 1'b1;
    end else if (seen_q && dist_q < DW'(DLL_GAP)) begin
      dist_q <= dist_q + DW'(1);
    end
  end

  p_cke_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_o |=> cke_o);
  p_nop_cke_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_o |-> is_nop);
  p_prea_a10_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_pre |-> a10_i);
  p_one_cycle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_nop |=> is_nop);
  p_dll_gap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ocd_def |-> (seen_q && dist_q >= DW'(DLL_GAP)));
  p_done_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |=> init_done_o);
  p_done_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |-> (cke_o && is_nop));

endmodule

bind ddr2_init_seq ddr2_init_chk #(.DLL_GAP(DLL_GAP)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cke_o(cke_o),
  .cs_no(cs_no), .ras_no(ras_no), .cas_no(cas_no), .we_no(we_no),
  .a10_i(addr_o[10]), .a987_i(addr_o[9:7]), .ba_i(ba_o),
  .init_done_o(init_done_o)
);

// File: tb/ddr2_init_seq_mon.sv
module ddr2_init_seq_mon #(
  parameter int    CLK_PS      = 8000,
  parameter int    T_STABLE_NS = 2000,
  parameter int    T_CKE_NS    = 400,
  parameter int    T_RP_PS     = 15000,
  parameter int    T_MRD_PS    = 12000,
  parameter int    T_RFC_PS    = 75000,
  parameter int    REF_N       = 2,
  parameter int    DLL_GAP     = 200,
  parameter string NAME        = "dut"
) (
  input logic        clk,
  input logic        rst_n,
  input logic        pg,
  input logic [12:0] mr,
  input logic [12:0] e1,
  input logic [12:0] e2,
  input logic [12:0] e3,
  input logic        cke,
  input logic        cs_n,
  input logic        ras_n,
  input logic        cas_n,
  input logic        we_n,
  input logic        odt,
  input logic [1:0]  ba,
  input logic [12:0] addr,
  input logic        done
);

  localparam int E_STB0 = (T_STABLE_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int E_CKE0 = (T_CKE_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int E_RP0  = (T_RP_PS + CLK_PS - 1) / CLK_PS;
  localparam int E_MRD0 = (T_MRD_PS + CLK_PS - 1) / CLK_PS;
  localparam int E_RFC0 = (T_RFC_PS + CLK_PS - 1) / CLK_PS;
  localparam int E_STB  = E_STB0 < 1 ? 1 : E_STB0;
  localparam int E_CKE  = E_CKE0 < 1 ? 1 : E_CKE0;
  localparam int E_RP   = E_RP0 < 2 ? 2 : E_RP0;
  localparam int E_MRD  = E_MRD0 < 2 ? 2 : E_MRD0;
  localparam int E_RFC  = E_RFC0 < 2 ? 2 : E_RFC0;
  localparam int E_REF  = REF_N < 2 ? 2 : REF_N;
  localparam int E_N    = 9 + E_REF;
  localparam logic [3:0] NOP = 4'b0111;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit started = 0;
  int t_go = 0;
  int n_cmd = 0;
  int t_cke = -1;
  int t_done = -1;
  bit bad_pre = 0, bad_post = 0, bad_odt = 0;
  logic [3:0]  rec_code [32];
  logic [1:0]  rec_ba   [32];
  logic [12:0] rec_addr [32];
  int          rec_t    [32];

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (rst_n && pg && !started) begin
      started = 1;
      t_go = cyc;
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      started = 0; n_cmd = 0; t_cke = -1; t_done = -1;
      bad_pre = 0; bad_post = 0; bad_odt = 0;
    end else begin
      if (odt) bad_odt = 1;
      if (!started || cyc < t_go + E_STB) begin
        if (cke || {cs_n, ras_n, cas_n, we_n} != NOP || done || ba != 0 || addr != 0)
          bad_pre = 1;
      end else if (cke && t_cke < 0) t_cke = cyc;
      if ({cs_n, ras_n, cas_n, we_n} != NOP && n_cmd < 32) begin
        rec_code[n_cmd] = {cs_n, ras_n, cas_n, we_n};
        rec_ba[n_cmd]   = ba;
        rec_addr[n_cmd] = addr;
        rec_t[n_cmd]    = cyc;
        n_cmd++;
      end
      if (done && t_done < 0) t_done = cyc;
      if (t_done >= 0 && (!done || !cke || {cs_n, ras_n, cas_n, we_n} != NOP))
        bad_post = 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s %s actual=%0h expected=%0h", NAME, tag, what, act, exp);
    end
  endtask

  task automatic verify();
    int t_exp, t_dll, t_exit, n_ref_seen;
    logic [3:0] ec;
    logic [1:0] eb;
    logic [12:0] ea, e1b;
    int gap;
    string tg;
    e1b = e1 & ~13'h0381;
    chk(n_cmd == E_N, "R3", "command count", n_cmd, E_N);
    chk(t_cke == t_go + E_STB, "R2", "cke rise cycle", t_cke - t_go, E_STB);
    chk(!bad_pre, "R2", "bus quiet before cke", int'(bad_pre), 0);
    t_exp = t_go + E_STB + E_CKE;
    t_dll = 0; t_exit = 0; n_ref_seen = 0;
    for (int i = 0; i < E_N && i < n_cmd; i++) begin
      eb = 2'd0; ea = 13'h0; ec = 4'b0000; gap = E_MRD; tg = "R5";
      if (i == 0 || i == 5) begin ec = 4'b0010; ea = 13'h0400; gap = E_RP; tg = "R4"; end
      else if (i == 1) begin eb = 2'd2; ea = e2; end
      else if (i == 2) begin eb = 2'd3; ea = e3; end
      else if (i == 3) begin eb = 2'd1; ea = e1b; end
      else if (i == 4) begin ea = mr | 13'h0100; end
      else if (i < 6 + E_REF) begin ec = 4'b0001; gap = E_RFC; tg = "R4"; end
      else if (i == 6 + E_REF) begin ea = mr & ~13'h0100; end
      else if (i == 7 + E_REF) begin eb = 2'd1; ea = e1b | 13'h0380; end
      else begin eb = 2'd1; ea = e1b; end
      if (i == 7 + E_REF && t_exp < t_dll + DLL_GAP + 1) t_exp = t_dll + DLL_GAP + 1;
      if (rec_code[i] == 4'b0001) n_ref_seen++;
      chk(rec_code[i] == ec, "R3", $sformatf("code step %0d", i), int'(rec_code[i]), int'(ec));
      chk(rec_ba[i] == eb && rec_addr[i] == ea, tg, $sformatf("ba/addr step %0d", i),
          int'({rec_ba[i], rec_addr[i]}), int'({eb, ea}));
      chk(rec_t[i] == t_exp, (i == 7 + E_REF) ? "R7" : "R6",
          $sformatf("issue cycle step %0d", i), rec_t[i] - t_go, t_exp - t_go);
      if (i == 4) t_dll = t_exp;
      t_exit = t_exp;
      t_exp = t_exp + gap;
    end
    if (n_cmd == E_N)
      chk(rec_t[7 + E_REF] - rec_t[4] >= DLL_GAP, "R7", "dll reset to ocd distance",
          rec_t[7 + E_REF] - rec_t[4], DLL_GAP);
    chk(n_ref_seen == E_REF, "R11", "refresh count", n_ref_seen, E_REF);
    chk(t_done == t_exit + E_MRD, "R9", "done cycle", t_done - t_go, t_exit + E_MRD - t_go);
    chk(!bad_post, "R9", "idle bus after done", int'(bad_post), 0);
    chk(!bad_odt, "R8", "odt stays low", int'(bad_odt), 0);
  endtask

endmodule

// File: tb/ddr2_init_seq_tb_top.sv
`timescale 1ns/1ps
module ddr2_init_seq_tb_top;

  logic clk = 0;
  logic rst_n = 0;
  logic pg = 0;
  logic [12:0] mr, e1, e2, e3;
  logic cke1, cs1, ras1, cas1, we1, odt1, done1;
  logic cke2, cs2, ras2, cas2, we2, odt2, done2;
  logic [1:0] ba1, ba2;
  logic [12:0] addr1, addr2;
  int n_chk = 0;
  int n_fail = 0;
  int wd = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  ddr2_init_seq #(.CLK_PS(8000), .T_STABLE_NS(2000), .T_CKE_NS(400), .T_RP_PS(15000),
    .T_MRD_PS(12000), .T_RFC_PS(75000), .REF_N(3), .DLL_GAP(200), .ADDR_W(13)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pwr_good_i(pg),
    .mr_fields_i(mr), .emr1_fields_i(e1), .emr2_fields_i(e2), .emr3_fields_i(e3),
    .cke_o(cke1), .cs_no(cs1), .ras_no(ras1), .cas_no(cas1), .we_no(we1), .odt_o(odt1),
    .ba_o(ba1), .addr_o(addr1), .init_done_o(done1));

  ddr2_init_seq #(.CLK_PS(8000), .T_STABLE_NS(1000), .T_CKE_NS(300), .T_RP_PS(30000),
    .T_MRD_PS(8000), .T_RFC_PS(100000), .REF_N(1), .DLL_GAP(20), .ADDR_W(13)) dut2_i (
    .clk_i(clk), .rst_ni(rst_n), .pwr_good_i(pg),
    .mr_fields_i(~mr), .emr1_fields_i(~e1), .emr2_fields_i(~e2), .emr3_fields_i(~e3),
    .cke_o(cke2), .cs_no(cs2), .ras_no(ras2), .cas_no(cas2), .we_no(we2), .odt_o(odt2),
    .ba_o(ba2), .addr_o(addr2), .init_done_o(done2));

  ddr2_init_seq_mon #(.CLK_PS(8000), .T_STABLE_NS(2000), .T_CKE_NS(400), .T_RP_PS(15000),
    .T_MRD_PS(12000), .T_RFC_PS(75000), .REF_N(3), .DLL_GAP(200), .NAME("dut_i")) mon1_i (
    .clk(clk), .rst_n(rst_n), .pg(pg), .mr(mr), .e1(e1), .e2(e2), .e3(e3),
    .cke(cke1), .cs_n(cs1), .ras_n(ras1), .cas_n(cas1), .we_n(we1), .odt(odt1),
    .ba(ba1), .addr(addr1), .done(done1));

  ddr2_init_seq_mon #(.CLK_PS(8000), .T_STABLE_NS(1000), .T_CKE_NS(300), .T_RP_PS(30000),
    .T_MRD_PS(8000), .T_RFC_PS(100000), .REF_N(1), .DLL_GAP(20), .NAME("dut2_i")) mon2_i (
    .clk(clk), .rst_n(rst_n), .pg(pg), .mr(~mr), .e1(~e1), .e2(~e2), .e3(~e3),
    .cke(cke2), .cs_n(cs2), .ras_n(ras2), .cas_n(cas2), .we_n(we2), .odt(odt2),
    .ba(ba2), .addr(addr2), .done(done2));

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // cke, done, command, ba, addr of both instances must be idle
  task automatic chk_idle(input string tag);
    chk({cke1, done1, cs1, ras1, cas1, we1, ba1, addr1} == {6'b000111, 15'h0}, tag,
        "dut_i idle bus", int'({cke1, done1, cs1, ras1, cas1, we1, ba1, addr1}), int'({6'b000111, 15'h0}));
    chk({cke2, done2, cs2, ras2, cas2, we2, ba2, addr2} == {6'b000111, 15'h0}, tag,
        "dut2_i idle bus", int'({cke2, done2, cs2, ras2, cas2, we2, ba2, addr2}), int'({6'b000111, 15'h0}));
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d",
             n_chk + mon1_i.n_chk + mon2_i.n_chk, n_fail + mon1_i.n_fail + mon2_i.n_fail);
    finished = 1;
    $finish;
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000 && !finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", wd, 150000);
      finish_run();
    end
  end

  initial begin
    mr = 0; e1 = 0; e2 = 0; e3 = 0;
    repeat (3) @(negedge clk);
    chk_idle("R1");
    rst_n = 1;
    repeat (30) @(negedge clk);
    chk_idle("R1");
    for (int p = 0; p < 5; p++) begin
      case (p)
        0: begin mr = 13'h0000; e1 = 13'h0000; e2 = 13'h0000; e3 = 13'h0000; end
        1: begin mr = 13'h1fff; e1 = 13'h1fff; e2 = 13'h1fff; e3 = 13'h1fff; end
        2: begin mr = 13'h0a53; e1 = 13'h1381; e2 = 13'h0155; e3 = 13'h02aa; end
        3: begin mr = 13'h1555; e1 = 13'h0aaa; e2 = 13'h0f0f; e3 = 13'h10f0; end
        default: begin mr = 13'h0eff; e1 = 13'h007e; e2 = 13'h1001; e3 = 13'h0800; end
      endcase
      if (p == 0) pg = 1;
      else begin
        rst_n = 0;
        @(negedge clk);
        chk_idle("R10");
        rst_n = 1;
      end
      if (p == 2) begin
        repeat (200) @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        chk_idle("R10");
        @(negedge clk);
        chk_idle("R10");
        rst_n = 1;
      end
      begin
        int k;
        k = 0;
        while (!(done1 && done2) && k < 5000) begin
          @(negedge clk);
          k++;
        end
        chk(done1 && done2, "R9", "both instances finished", int'({done1, done2}), 3);
      end
      repeat (20) @(negedge clk);
      mon1_i.verify();
      mon2_i.verify();
    end
    finish_run();
  end

endmodule